// File: doc/BRIEF.md
# Address Register Update Generator

This block forms the effective address for a memory-referencing instruction and advances the address register that instruction names. It holds a bank of address registers and a matching bank of offset registers. Each cycle a 3-bit mode and a register index select one address/offset pair. The block drives the effective address combinationally from the current register contents, or from an extension word in absolute mode. It also works out the value to write back into the selected address register.

The write-back is committed on the clock edge where `step_en` is high. No other qualifier gates it. A conditional instruction whose test fails, such as an untaken conditional subroutine call, still updates its address register, so the instruction sequencer must not gate `step_en` with the outcome of the condition. A separate load port writes any address or offset register directly. The output `ext_needed` tells the fetch logic that the current mode uses one extra program word.

Top module: `addr_update_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every address and offset register is cleared to zero.
- R2: With `ld_en` high, `ld_data` is written at the clock edge into address register `ld_idx` when `ld_off` is 0, or into offset register `ld_idx` when `ld_off` is 1.
- R3: Mode 1 (post-add offset) gives `ea` = Rn and writes Rn+Nn back to Rn. Mode 0 (post-subtract offset) gives `ea` = Rn and writes Rn-Nn back to Rn.
- R4: Mode 3 (post-increment) gives `ea` = Rn and writes Rn+1 back to Rn. Mode 2 (post-decrement) gives `ea` = Rn and writes Rn-1 back to Rn.
- R5: Mode 4 (indirect) gives `ea` = Rn and leaves Rn unchanged when stepped.
- R6: Mode 5 (indexed) gives `ea` = Rn+Nn and leaves Rn unchanged when stepped.
- R7: Mode 7 (predecrement) gives `ea` = Rn-1, and the step writes that same value back to Rn.
- R8: Mode 6 (absolute) gives `ea` = `ext_word`, leaves Rn unchanged, and is the only mode that raises `ext_needed`.
- R9: A register changes only through reset, the load port, or a step with `step_en` high. A step changes only the selected address register. Offset registers never change through a step.
- R10: If a load into address register k and a step on register k fall in the same cycle, the load value wins. If they target different registers, both take effect.
- R11: All address arithmetic wraps modulo 2^16. For example, 0xFFFF+2 gives 0x0001 and 0x0000-1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Addressing mode code (see R3 to R8) |
| reg_sel | input | 3 | Index of the address/offset pair in use |
| ext_word | input | 16 | Absolute address from the extension word |
| step_en | input | 1 | Commit the register update at this edge |
| ld_en | input | 1 | Direct register write strobe |
| ld_off | input | 1 | Load target: 0 address bank, 1 offset bank |
| ld_idx | input | 3 | Register index for the direct write |
| ld_data | input | 16 | Value for the direct write |
| ea | output | 16 | Effective address, combinational |
| ext_needed | output | 1 | Current mode consumes an extension word |

## Verification
The assertions assume that `mode` and `reg_sel` are stable across the clock edge where they are sampled. They also assume that a load aimed at the stepped address register is the only write that can compete with a step, and they exclude that case from the per-mode update checks. The bench changes every input only on the falling edge, so each step sees one settled mode and index. It sets up the load-versus-step collision only on purpose, in the conflict scenario, where the load-priority check covers it. The bench reads registers back through the indirect and indexed modes with `step_en` low, so reading never disturbs the state it observes.

// File: rtl/agu_pkg.sv
// Package: shared mode encoding for the address register update generator.
// Assumes: a 3-bit mode field; all eight codes are meaningful.
package agu_pkg;
    typedef enum logic [2:0] {
        AM_POST_SUB = 3'd0,
        AM_POST_ADD = 3'd1,
        AM_POST_DEC = 3'd2,
        AM_POST_INC = 3'd3,
        AM_INDIRECT = 3'd4,
        AM_INDEXED  = 3'd5,
        AM_ABSOLUTE = 3'd6,
        AM_PRE_DEC  = 3'd7
    } agu_mode_e;
endpackage

// File: rtl/agu_regbank.sv
// Module: agu_regbank
// Holds the address and offset register banks. Has two write paths: the
// direct load port and the step update port, which only reaches the address
// bank. Assumes a synchronous active-low reset; on a same-register collision
// the load has priority.
module agu_regbank #(
    parameter int AW    = 16,
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic                      ld_off,
    input  logic [IDXW-1:0]           ld_idx,
    input  logic [AW-1:0]             ld_data,
    input  logic                      up_en,
    input  logic [IDXW-1:0]           up_idx,
    input  logic [AW-1:0]             up_data,
    output logic [NREGS-1:0][AW-1:0]  r_q,
    output logic [NREGS-1:0][AW-1:0]  n_q
);

    // Address bank: reset, then load (priority), then step update.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n)
                r_q[i] <= '0;
            else if (ld_en && !ld_off && ld_idx == IDXW'(i))
                r_q[i] <= ld_data;
            else if (up_en && up_idx == IDXW'(i))
                r_q[i] <= up_data;
        end
    end

    // Offset bank: reset or direct load only.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n)
                n_q[i] <= '0;
            else if (ld_en && ld_off && ld_idx == IDXW'(i))
                n_q[i] <= ld_data;
        end
    end

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && !ld_off |=> r_q[$past(ld_idx)] == $past(ld_data));

    // R2
    load_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && ld_off |=> n_q[$past(ld_idx)] == $past(ld_data));

    // R9
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && ld_off) |=> $stable(n_q));

endmodule

// File: rtl/agu_ea_calc.sv
// Module: agu_ea_calc
// Pure combinational datapath. From the selected address/offset pair it
// forms the effective address, the write-back value and a write-back flag
// for each mode. Assumes wrap-around arithmetic at AW bits.
module agu_ea_calc
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [2:0]    mode,
    input  logic [AW-1:0] r_cur,
    input  logic [AW-1:0] n_cur,
    input  logic [AW-1:0] ext_word,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] r_next,
    output logic          wb,
    output logic          ext_needed
);

    agu_mode_e md;
    logic [AW-1:0] r_plus_n, r_minus_n, r_inc, r_dec;

    // Shared adders for all modes.
    always_comb begin
        md        = agu_mode_e'(mode);
        r_plus_n  = r_cur + n_cur;
        r_minus_n = r_cur - n_cur;
        r_inc     = r_cur + AW'(1);
        r_dec     = r_cur - AW'(1);
    end

    // Per-mode selection of address, write-back value and flags.
    always_comb begin
        ea         = r_cur;
        r_next     = r_cur;
        wb         = 1'b0;
        ext_needed = 1'b0;
        unique case (md)
            AM_POST_SUB: begin r_next = r_minus_n; wb = 1'b1; end
            AM_POST_ADD: begin r_next = r_plus_n;  wb = 1'b1; end
            AM_POST_DEC: begin r_next = r_dec;     wb = 1'b1; end
            AM_POST_INC: begin r_next = r_inc;     wb = 1'b1; end
            AM_INDIRECT: ;
            AM_INDEXED:  ea = r_plus_n;
            AM_ABSOLUTE: begin ea = ext_word; ext_needed = 1'b1; end
            AM_PRE_DEC:  begin ea = r_dec; r_next = r_dec; wb = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/addr_update_gen.sv
// Module: addr_update_gen (top)
// Selects one address/offset pair by reg_sel, drives the effective address
// combinationally and commits the address update whenever step_en is high,
// with no condition qualifier. Assumes mode and reg_sel are held across the
// sampling edge.
module addr_update_gen #(
    parameter int AW    = 16,
    parameter int NREGS = 8,
    localparam int IDXW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode,
    input  logic [IDXW-1:0] reg_sel,
    input  logic [AW-1:0]   ext_word,
    input  logic            step_en,
    input  logic            ld_en,
    input  logic            ld_off,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [AW-1:0]   ld_data,
    output logic [AW-1:0]   ea,
    output logic            ext_needed
);

    logic [NREGS-1:0][AW-1:0] r_q, n_q;
    logic [AW-1:0] r_cur, n_cur, r_next;
    logic          wb, up_en, ld_hits_sel;

    // Read the selected pair and qualify the write-back with the step strobe.
    always_comb begin
        r_cur       = r_q[reg_sel];
        n_cur       = n_q[reg_sel];
        up_en       = step_en && wb;
        ld_hits_sel = ld_en && !ld_off && (ld_idx == reg_sel);
    end

    agu_regbank #(.AW(AW), .NREGS(NREGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_off  (ld_off),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .up_en   (up_en),
        .up_idx  (reg_sel),
        .up_data (r_next),
        .r_q     (r_q),
        .n_q     (n_q)
    );

    agu_ea_calc #(.AW(AW)) u_calc (
        .mode       (mode),
        .r_cur      (r_cur),
        .n_cur      (n_cur),
        .ext_word   (ext_word),
        .ea         (ea),
        .r_next     (r_next),
        .wb         (wb),
        .ext_needed (ext_needed)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (r_q == '0) && (n_q == '0));

    // R3
    post_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && mode == 3'd1 && !ld_hits_sel
        |=> r_q[$past(reg_sel)] == $past(r_cur) + $past(n_cur));

    // R7
    pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && mode == 3'd7 && !ld_hits_sel
        |=> r_q[$past(reg_sel)] == $past(ea));

    // R5 R6 R8
    no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && mode inside {3'd4, 3'd5, 3'd6} && !ld_en
        |=> $stable(r_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en && !ld_en |=> $stable(r_q));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && ld_hits_sel |=> r_q[$past(reg_sel)] == $past(ld_data));

endmodule

// File: tb/tb_addr_update_gen.sv
module tb_addr_update_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  mode = 3'd4;
    logic [2:0]  reg_sel = '0;
    logic [15:0] ext_word = '0;
    logic        step_en = 0;
    logic        ld_en = 0;
    logic        ld_off = 0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] ea;
    logic        ext_needed;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mr [8];
    logic [15:0] mn [8];

    addr_update_gen dut (.*);

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_r(input int idx, output logic [15:0] v);
        step_en = 0; mode = 3'd4; reg_sel = 3'(idx); #1; v = ea;
    endtask

    task automatic rd_n(input int idx, output logic [15:0] v);
        logic [15:0] r;
        rd_r(idx, r);
        mode = 3'd5; #1; v = ea - r;
    endtask

    task automatic load(input bit off, input int idx, input logic [15:0] d);
        ld_en = 1; ld_off = off; ld_idx = 3'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 0;
        if (off) mn[idx] = d; else mr[idx] = d;
    endtask

    function automatic logic [15:0] exp_ea(input logic [2:0] m, input logic [15:0] r, input logic [15:0] n, input logic [15:0] x);
        case (m)
            3'd5: return r + n;
            3'd6: return x;
            3'd7: return r - 16'd1;
            default: return r;
        endcase
    endfunction

    function automatic logic [15:0] exp_next(input logic [2:0] m, input logic [15:0] r, input logic [15:0] n);
        case (m)
            3'd0: return r - n;
            3'd1: return r + n;
            3'd2: return r - 16'd1;
            3'd3: return r + 16'd1;
            3'd7: return r - 16'd1;
            default: return r;
        endcase
    endfunction

    // One stepped access: checks ea and ext_needed before the edge, then the register file after.
    task automatic step_chk(input logic [2:0] m, input int idx, input logic [15:0] x, input string tag);
        logic [15:0] v;
        mode = m; reg_sel = 3'(idx); ext_word = x; step_en = 1; #1;
        check(ea == exp_ea(m, mr[idx], mn[idx], x), {tag, " ea"}, ea, exp_ea(m, mr[idx], mn[idx], x));
        check(ext_needed == (m == 3'd6), {tag, " R8 ext_needed"}, 16'(ext_needed), 16'(m == 3'd6));
        mr[idx] = exp_next(m, mr[idx], mn[idx]);
        @(negedge clk);
        step_en = 0;
        for (int k = 0; k < 8; k++) begin
            rd_r(k, v);
            check(v == mr[k], {tag, " R9 reg after step"}, v, mr[k]);
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int k = 0; k < 8; k++) begin
            rd_r(k, v); check(v == 0, "R1 addr reg reset", v, 0);
            rd_n(k, v); check(v == 0, "R1 offset reg reset", v, 0);
        end
    endtask

    task automatic t_load();
        logic [15:0] v;
        for (int k = 0; k < 8; k++) begin
            load(0, k, 16'h1000 * 16'(k) + 16'h0123);
            load(1, k, 16'h0010 + 16'(k));
        end
        for (int k = 0; k < 8; k++) begin
            rd_r(k, v); check(v == mr[k], "R2 addr load", v, mr[k]);
            rd_n(k, v); check(v == mn[k], "R2 offset load", v, mn[k]);
        end
    endtask

    task automatic t_post_offset();
        step_chk(3'd1, 2, 0, "R3 post-add");
        step_chk(3'd0, 5, 0, "R3 post-sub");
        load(0, 3, 16'hFFFF); load(1, 3, 16'h0002);
        step_chk(3'd1, 3, 0, "R11 post-add wrap");
        load(0, 4, 16'h0001); load(1, 4, 16'h0005);
        step_chk(3'd0, 4, 0, "R11 post-sub wrap");
    endtask

    task automatic t_inc_dec();
        step_chk(3'd3, 1, 0, "R4 post-inc");
        step_chk(3'd2, 6, 0, "R4 post-dec");
        load(0, 0, 16'h0000);
        step_chk(3'd2, 0, 0, "R11 post-dec wrap");
        load(0, 0, 16'hFFFF);
        step_chk(3'd3, 0, 0, "R11 post-inc wrap");
    endtask

    task automatic t_no_update();
        step_chk(3'd4, 7, 0, "R5 indirect");
        step_chk(3'd5, 2, 0, "R6 indexed");
        step_chk(3'd6, 5, 16'hBEEF, "R8 absolute");
    endtask

    task automatic t_predec();
        step_chk(3'd7, 1, 0, "R7 predec");
        load(0, 1, 16'h0000);
        step_chk(3'd7, 1, 0, "R7 predec wrap");
    endtask

    task automatic t_hold();
        logic [15:0] v;
        mode = 3'd1; reg_sel = 3'd2; step_en = 0;
        @(negedge clk); @(negedge clk);
        rd_r(2, v); check(v == mr[2], "R9 no step no change", v, mr[2]);
        for (int k = 0; k < 8; k++) begin
            rd_n(k, v); check(v == mn[k], "R9 offsets untouched", v, mn[k]);
        end
    endtask

    task automatic t_conflict();
        logic [15:0] v;
        mode = 3'd3; reg_sel = 3'd4; step_en = 1;
        ld_en = 1; ld_off = 0; ld_idx = 3'd4; ld_data = 16'h5A5A;
        @(negedge clk);
        step_en = 0; ld_en = 0; mr[4] = 16'h5A5A;
        rd_r(4, v); check(v == 16'h5A5A, "R10 load wins", v, 16'h5A5A);
        mode = 3'd3; reg_sel = 3'd6; step_en = 1;
        ld_en = 1; ld_idx = 3'd7; ld_data = 16'hC3C3;
        @(negedge clk);
        step_en = 0; ld_en = 0;
        mr[6] = mr[6] + 16'd1; mr[7] = 16'hC3C3;
        rd_r(6, v); check(v == mr[6], "R10 step on other reg", v, mr[6]);
        rd_r(7, v); check(v == mr[7], "R10 load on other reg", v, mr[7]);
    endtask

    task automatic t_random();
        for (int it = 0; it < 150; it++) begin
            int idx = $urandom_range(0, 7);
            if (it % 10 == 0) begin
                load(0, idx, 16'($urandom));
                load(1, idx, 16'($urandom));
            end
            step_chk(3'($urandom_range(0, 7)), idx, 16'($urandom), "R3 R11 random mode");
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) begin mr[k] = 0; mn[k] = 0; end
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        t_reset();
        t_load();
        t_post_offset();
        t_inc_dec();
        t_no_update();
        t_predec();
        t_hold();
        t_conflict();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule